// File: doc/BRIEF.md
# Programmable Interval Timer

This block holds several independent 16-bit down-counters (three by default) behind a small byte-wide host bus. Each counter has three signals: a count-enable pulse (`cntTick`) that stands for one input clock of the counter, a gate input and an output pin. Software picks a counter and its counting behaviour by writing a control byte. It then writes the initial count as two bytes, low byte first. It can read the running count back at any time, and it can freeze that count first so that both bytes belong to the same instant.

Six counting behaviours are provided:
- Mode 0: raises the output once at the end of a count.
- Mode 1: a gate-triggered one-shot.
- Mode 2: a divide-by-N rate generator.
- Mode 3: a square-wave divider.
- Mode 4: a single strobe armed by a count write.
- Mode 5: a single strobe armed by a gate edge.

Everything runs on one system clock. A counter acts only in clock cycles where its `cntTick` bit is high. Bus accesses are single-cycle strobes.

Top module: `pit_timer`

## Requirements
- R1: After reset every output is low, every counter holds zero and reads return 0x00.
- R2: A write to address 3 is a control byte. Bits [7:6] pick the counter (0 to 2). Bits [5:4] = 00 make it a latch command. Any other value programs the counter, with the mode in bits [3:1]. Mode codes 6 and 7 act as modes 2 and 3. Programming resets the byte pointers of that counter.
- R3: A count is written to the counter's own address, low byte then high byte. A count of 0 means 65,536. The count takes effect on the first tick after the high-byte write (the load tick).
- R4: Mode 0. The output goes low on programming and on each count write. With the gate high, the output rises on the N-th tick after the load tick and then stays high. While the gate is low, counting pauses.
- R5: Mode 1. The output is high while idle. A rising gate edge arms a trigger. On the next tick the count loads and the output goes low. The output rises N ticks later. A new trigger reloads the count and restarts the low pulse.
- R6: Mode 2. The output has a period of N ticks and is low for one tick of each period, on the (N-1)-th tick after each reload.
- R7: Mode 3. The output is high for ceil(N/2) ticks and low for floor(N/2) ticks, starting high at the load tick.
- R8: Mode 4. The output is low for exactly one tick, on the N-th tick after the load tick. It fires once per count write.
- R9: Mode 5. This mode behaves like mode 4, but the count loads only on the first tick after a rising gate edge.
- R10: A read of a counter address returns the low byte, then the high byte. After a latch command, reads return the frozen value until both bytes have been read.
- R11: Counters are independent: ticks and writes for one counter never change another counter's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cntTick | input | NUM_CH | Per-counter count enable, one input clock per high cycle |
| gate | input | NUM_CH | Per-counter gate / trigger input |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe, advances the read byte pointer |
| busAddr | input | 2 | 0..NUM_CH-1 counters, 3 control |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational from address |
| timerOut | output | NUM_CH | Counter outputs |

## Verification
The hardest condition to reach is a retrigger of the one-shot while its low pulse is still running. The gate must fall and rise again between ticks while the counter is mid-count. The bench holds `cntTick` low for those cycles, toggles the gate across two clock edges, and then resumes ticking, so the restart shows up as a longer low pulse. The largest count (a written 0) needs 65,536 ticks. It is reached by holding `cntTick` high over a long run and checking the output one tick before and at the end.

// File: rtl/pit_pkg.sv
package pit_pkg;

  localparam int PIT_CNT_W = 16;

  typedef enum logic [2:0] {
    MODE_TCINT    = 3'd0,
    MODE_ONESHOT  = 3'd1,
    MODE_RATE     = 3'd2,
    MODE_SQUARE   = 3'd3,
    MODE_SWSTROBE = 3'd4,
    MODE_HWSTROBE = 3'd5
  } pitMode_e;

  // strobes from a channel's control to its datapath
  typedef struct packed {
    logic                 modeWrite;
    logic                 countDone;
    pitMode_e             mode;
    logic [PIT_CNT_W-1:0] countVal;
  } chanCtrl_t;

  function automatic pitMode_e decodeMode(input logic [2:0] field);
    case (field)
      3'd6:    return MODE_RATE;
      3'd7:    return MODE_SQUARE;
      default: return pitMode_e'(field);
    endcase
  endfunction

endpackage

// File: rtl/pit_chan_ctrl.sv
module pit_chan_ctrl
  import pit_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 progWr,
  input  logic                 latchWr,
  input  logic                 countWr,
  input  logic                 readStb,
  input  logic [7:0]           wrData,
  input  logic [PIT_CNT_W-1:0] curCount,
  output chanCtrl_t            ctrlOut,
  output logic [7:0]           rdByte
);

  pitMode_e             modeQ;
  logic                 wrHigh;
  logic [7:0]           lowByte;
  logic                 rdHigh;
  logic                 latched;
  logic [PIT_CNT_W-1:0] latchVal;
  logic [PIT_CNT_W-1:0] readSrc;

  always_comb begin
    ctrlOut.modeWrite = progWr;
    ctrlOut.countDone = countWr & wrHigh;
    ctrlOut.mode      = progWr ? decodeMode(wrData[3:1]) : modeQ;
    ctrlOut.countVal  = {wrData, lowByte};
    readSrc           = latched ? latchVal : curCount;
    rdByte            = rdHigh ? readSrc[15:8] : readSrc[7:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ    <= MODE_TCINT;
      wrHigh   <= 1'b0;
      lowByte  <= '0;
      rdHigh   <= 1'b0;
      latched  <= 1'b0;
      latchVal <= '0;
    end else if (progWr) begin
      modeQ   <= decodeMode(wrData[3:1]);
      wrHigh  <= 1'b0;
      rdHigh  <= 1'b0;
      latched <= 1'b0;
    end else begin
      if (countWr) begin
        if (!wrHigh) lowByte <= wrData;
        wrHigh <= ~wrHigh;
      end
      if (latchWr && !latched) begin
        latched  <= 1'b1;
        latchVal <= curCount;
      end
      if (readStb) begin
        rdHigh <= ~rdHigh;
        if (rdHigh) latched <= 1'b0;
      end
    end
  end

  // R10: a frozen value is held until the readback completes
  assert_latch_held_R10: assert property (@(posedge clk) disable iff (rst)
    (latched && !readStb && !progWr) |=> (latched && $stable(latchVal)));

endmodule

// File: rtl/pit_chan_dp.sv
module pit_chan_dp
  import pit_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 gate,
  input  chanCtrl_t            ctrlIn,
  output logic                 chanOut,
  output logic [PIT_CNT_W-1:0] curCount
);

  localparam int RW = PIT_CNT_W + 1;

  logic [RW-1:0] cnt, reload;
  logic          outQ, loadPend, trigPend, running, armed, gatePrev;
  logic          gateRise, gateOk, hwTrig;
  pitMode_e      mode;

  function automatic logic [RW-1:0] halfUp(input logic [RW-1:0] n);
    return (n + RW'(1)) >> 1;
  endfunction

  function automatic logic [RW-1:0] halfDown(input logic [RW-1:0] n);
    return n >> 1;
  endfunction

  always_comb begin
    mode     = ctrlIn.mode;
    gateRise = gate & ~gatePrev;
    hwTrig   = (mode == MODE_ONESHOT) || (mode == MODE_HWSTROBE);
    gateOk   = hwTrig ? 1'b1 : gate;
    chanOut  = outQ;
    curCount = cnt[PIT_CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      reload   <= '0;
      outQ     <= 1'b0;
      loadPend <= 1'b0;
      trigPend <= 1'b0;
      running  <= 1'b0;
      armed    <= 1'b0;
      gatePrev <= 1'b0;
    end else begin
      gatePrev <= gate;
      if (ctrlIn.modeWrite) begin
        running  <= 1'b0;
        loadPend <= 1'b0;
        trigPend <= 1'b0;
        armed    <= 1'b0;
        outQ     <= (mode != MODE_TCINT);
      end else if (ctrlIn.countDone) begin
        reload <= (ctrlIn.countVal == '0) ? {1'b1, {PIT_CNT_W{1'b0}}}
                                          : {1'b0, ctrlIn.countVal};
        armed  <= 1'b1;
        if (!hwTrig) begin
          loadPend <= 1'b1;
          running  <= 1'b0;
        end
        if (mode == MODE_TCINT) outQ <= 1'b0;
      end else begin
        if (gateRise && armed && hwTrig) trigPend <= 1'b1;
        if (tick) begin
          if (loadPend || trigPend) begin
            loadPend <= 1'b0;
            trigPend <= 1'b0;
            running  <= 1'b1;
            cnt      <= (mode == MODE_SQUARE) ? halfUp(reload) : reload;
            outQ     <= !((mode == MODE_TCINT) || (mode == MODE_ONESHOT));
          end else if (running) begin
            case (mode)
              MODE_TCINT, MODE_ONESHOT: begin
                if (gateOk) begin
                  if (cnt == RW'(1)) begin
                    cnt     <= '0;
                    outQ    <= 1'b1;
                    running <= 1'b0;
                  end else begin
                    cnt <= cnt - RW'(1);
                  end
                end
              end
              MODE_RATE: begin
                if (gateOk) begin
                  if (cnt == RW'(1)) begin
                    cnt  <= reload;
                    outQ <= 1'b1;
                  end else begin
                    cnt <= cnt - RW'(1);
                    if (cnt == RW'(2)) outQ <= 1'b0;
                  end
                end
              end
              MODE_SQUARE: begin
                if (gateOk) begin
                  if (cnt == RW'(1)) begin
                    outQ <= ~outQ;
                    cnt  <= outQ ? halfDown(reload) : halfUp(reload);
                  end else begin
                    cnt <= cnt - RW'(1);
                  end
                end
              end
              default: begin
                if (cnt == '0) begin
                  outQ    <= 1'b1;
                  running <= 1'b0;
                end else if (gateOk) begin
                  if (cnt == RW'(1)) outQ <= 1'b0;
                  cnt <= cnt - RW'(1);
                end
              end
            endcase
          end
        end
      end
    end
  end

  // R8/R9: the strobe low lasts a single tick
  assert_strobe_one_tick_R8: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_SWSTROBE || mode == MODE_HWSTROBE) && !outQ && tick
      && !ctrlIn.modeWrite && !ctrlIn.countDone) |=> outQ);

  // R4: once the terminal count is reached the output holds high
  assert_tc_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_TCINT && outQ && !ctrlIn.modeWrite && !ctrlIn.countDone) |=> outQ);

  // R5: the one-shot pulse only starts on a tick
  assert_oneshot_start_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(outQ) && mode == MODE_ONESHOT) |-> $past(tick));

  // R7: a running square wave never sits at a zero half-count
  assert_square_live_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SQUARE && running) |-> (cnt != '0));

endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] cntTick,
  input  logic [NUM_CH-1:0] gate,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [1:0]        busAddr,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  output logic [NUM_CH-1:0] timerOut
);

  localparam logic [1:0] CTRL_ADDR = 2'd3;

  logic       ctrlHit, isLatch;
  logic [1:0] selField;
  logic [7:0] rdBytes [NUM_CH];

  always_comb begin
    ctrlHit  = busWr && (busAddr == CTRL_ADDR);
    selField = busWrData[7:6];
    isLatch  = (busWrData[5:4] == 2'b00);
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    chanCtrl_t             ctrlLink;
    logic [PIT_CNT_W-1:0]  countNow;
    logic                  progWr, latchWr, countWr, readStb;

    always_comb begin
      progWr  = ctrlHit && (selField == 2'(i)) && !isLatch;
      latchWr = ctrlHit && (selField == 2'(i)) && isLatch;
      countWr = busWr && (busAddr == 2'(i));
      readStb = busRd && (busAddr == 2'(i));
    end

    pit_chan_ctrl u_ctrl (
      .clk(clk), .rst(rst), .progWr(progWr), .latchWr(latchWr),
      .countWr(countWr), .readStb(readStb), .wrData(busWrData),
      .curCount(countNow), .ctrlOut(ctrlLink), .rdByte(rdBytes[i])
    );

    pit_chan_dp u_dp (
      .clk(clk), .rst(rst), .tick(cntTick[i]), .gate(gate[i]),
      .ctrlIn(ctrlLink), .chanOut(timerOut[i]), .curCount(countNow)
    );
  end

  always_comb begin
    busRdData = 8'h00;
    for (int k = 0; k < NUM_CH; k++)
      if (busAddr == 2'(k)) busRdData = rdBytes[k];
  end

endmodule

// File: tb/tb_pit_timer.sv
module tb_pit_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst = 1'b1;
  logic [2:0] cntTick = 3'b000, gate = 3'b101;
  logic       busWr = 1'b0, busRd = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic [2:0] timerOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  pit_timer dut (
    .clk(clk), .rst(rst), .cntTick(cntTick), .gate(gate), .busWr(busWr),
    .busRd(busRd), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .timerOut(timerOut)
  );

  typedef struct {
    bit         isRead;
    int         ch;
    logic [7:0] val;
    string      tag;
  } item_t;

  item_t expQ[$];
  item_t cur;
  int    checks = 0, fails = 0;

  // monitor: compares queued expectations mid-cycle
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      cur = expQ.pop_front();
      checks++;
      if (cur.isRead) begin
        if (busRdData !== cur.val) begin
          fails++;
          $display("FAIL %s: read got %h expected %h", cur.tag, busRdData, cur.val);
        end
      end else if (timerOut[cur.ch] !== cur.val[0]) begin
        fails++;
        $display("FAIL %s: out%0d got %b expected %b", cur.tag, cur.ch,
                 timerOut[cur.ch], cur.val[0]);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWr = 1'b1; step(); busWr = 1'b0;
  endtask

  task automatic prog(input int ch, input int mode);
    wr(2'd3, {ch[1:0], 2'b11, mode[2:0], 1'b0});
  endtask

  task automatic loadCnt(input int ch, input int n);
    wr(ch[1:0], n[7:0]); wr(ch[1:0], n[15:8]);
  endtask

  task automatic tick(input int ch);
    cntTick[ch] = 1'b1; step(); cntTick = 3'b000;
  endtask

  task automatic tickN(input int ch, input int n);
    for (int k = 0; k < n; k++) tick(ch);
  endtask

  task automatic expOut(input int ch, input logic v, input string tag);
    item_t it;
    it.isRead = 1'b0; it.ch = ch; it.val = {7'b0, v}; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic readExp(input int ch, input logic [7:0] v, input string tag);
    item_t it;
    it.isRead = 1'b1; it.ch = ch; it.val = v; it.tag = tag;
    busAddr = ch[1:0]; busRd = 1'b1;
    expQ.push_back(it);
    step(); busRd = 1'b0;
  endtask

  task automatic finishRun();
    step(); step();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: run did not end");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    for (int c = 0; c < 3; c++) expOut(c, 1'b0, "R1 reset output");
    readExp(0, 8'h00, "R1 reset read");

    // R4 terminal count, N=5
    prog(0, 0);
    expOut(0, 1'b0, "R4 low after program");
    loadCnt(0, 5);
    tick(0);
    tickN(0, 4);
    expOut(0, 1'b0, "R4 one tick before end");
    tick(0);
    expOut(0, 1'b1, "R4 rises at N");
    tickN(0, 3);
    expOut(0, 1'b1, "R4 stays high");

    // R4 gate low pauses
    gate[0] = 1'b0;
    prog(0, 0);
    loadCnt(0, 3);
    tick(0);
    tickN(0, 5);
    expOut(0, 1'b0, "R4 gate paused");
    gate[0] = 1'b1;
    tickN(0, 2);
    expOut(0, 1'b0, "R4 resumed not done");
    tick(0);
    expOut(0, 1'b1, "R4 resumed done");

    // R10 + R2 latch command
    prog(0, 0);
    loadCnt(0, 300);
    tick(0);
    tickN(0, 3);
    wr(2'd3, 8'h00);
    tickN(0, 2);
    readExp(0, 8'h29, "R10 latched low byte");
    readExp(0, 8'h01, "R10 latched high byte");
    readExp(0, 8'h27, "R10 live low byte");
    readExp(0, 8'h01, "R10 live high byte");

    // R5 one-shot on ch1, N=3
    prog(1, 1);
    expOut(1, 1'b1, "R5 idle high");
    loadCnt(1, 3);
    tickN(1, 2);
    expOut(1, 1'b1, "R5 waits for trigger");
    gate[1] = 1'b1; step();
    tick(1);
    expOut(1, 1'b0, "R5 trigger drives low");
    tickN(1, 2);
    expOut(1, 1'b0, "R5 still low");
    tick(1);
    expOut(1, 1'b1, "R5 ends high");
    tickN(1, 2);
    expOut(1, 1'b1, "R5 stays high");
    gate[1] = 1'b0; step(); gate[1] = 1'b1; step();
    tick(1);
    tickN(1, 2);
    gate[1] = 1'b0; step(); gate[1] = 1'b1; step();
    tick(1);
    tickN(1, 2);
    expOut(1, 1'b0, "R5 retrigger restarts");
    tick(1);
    expOut(1, 1'b1, "R5 retrigger end");

    // R6 rate generator on ch2, N=4
    prog(2, 2);
    loadCnt(2, 4);
    tick(2);
    expOut(2, 1'b1, "R6 high at load");
    for (int k = 1; k <= 8; k++) begin
      tick(2);
      expOut(2, (k % 4 == 3) ? 1'b0 : 1'b1, "R6 rate pattern");
    end
    expOut(1, 1'b1, "R11 ch1 unaffected");

    // R7 square wave, N=5 then N=4
    prog(2, 3);
    loadCnt(2, 5);
    tick(2);
    for (int k = 1; k <= 10; k++) begin
      tick(2);
      expOut(2, (k % 5 == 3 || k % 5 == 4) ? 1'b0 : 1'b1, "R7 odd square");
    end
    prog(2, 3);
    loadCnt(2, 4);
    tick(2);
    for (int k = 1; k <= 4; k++) begin
      tick(2);
      expOut(2, (k == 2 || k == 3) ? 1'b0 : 1'b1, "R7 even square");
    end

    // R2 alias: mode code 6 acts as rate generator
    prog(2, 6);
    loadCnt(2, 2);
    tick(2);
    expOut(2, 1'b1, "R2 alias load");
    tick(2);
    expOut(2, 1'b0, "R2 alias low");
    tick(2);
    expOut(2, 1'b1, "R2 alias high");

    // R8 software strobe, N=3 then rewrite N=2
    prog(1, 4);
    expOut(1, 1'b1, "R8 idle high");
    loadCnt(1, 3);
    tick(1);
    for (int k = 1; k <= 6; k++) begin
      tick(1);
      expOut(1, (k == 3) ? 1'b0 : 1'b1, "R8 single strobe");
    end
    loadCnt(1, 2);
    tick(1);
    for (int k = 1; k <= 3; k++) begin
      tick(1);
      expOut(1, (k == 2) ? 1'b0 : 1'b1, "R8 rewrite strobe");
    end

    // R9 hardware strobe, N=2
    gate[1] = 1'b0;
    prog(1, 5);
    loadCnt(1, 2);
    tickN(1, 3);
    expOut(1, 1'b1, "R9 no trigger no strobe");
    gate[1] = 1'b1; step();
    tick(1);
    expOut(1, 1'b1, "R9 load tick");
    for (int k = 1; k <= 3; k++) begin
      tick(1);
      expOut(1, (k == 2) ? 1'b0 : 1'b1, "R9 gated strobe");
    end

    // R3 count of 0 means 65536
    prog(0, 0);
    loadCnt(0, 0);
    tick(0);
    cntTick[0] = 1'b1;
    repeat (65535) step();
    cntTick = 3'b000;
    expOut(0, 1'b0, "R3 one tick short of max");
    tick(0);
    expOut(0, 1'b1, "R3 max count reached");

    finishRun();
  end

endmodule